// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small 8-bit CPU core and decides which of its interrupt sources is serviced next. Each source has a pending flag, an enable bit, a level bit (low or high) and an entry-clear bit. There is also one global enable. Sources report events as one-cycle strobes. A pending flag latches on any event, even when nothing is enabled. A request is offered to the CPU only at an instruction boundary. The controller then presents the chosen source index and its service-routine start address until the CPU accepts the call.

Two in-service bits track which levels are being serviced. A high-level request may interrupt a low-level routine. Nothing interrupts a high-level routine, and a low-level request never interrupts a low-level routine. A return strobe retires the highest active level.

Clearing the global enable leaves a one-instruction window. A shadow copy of the enable is refreshed only at instruction boundaries. This copy can still admit a request at the boundary that ends the clearing instruction, but only if the CPU reports that the next instruction is single-cycle. The readable global enable shows 0 at once.

The control state machine has two states. `ST_IDLE` waits for a boundary. The launch transition `ST_IDLE -> ST_OFFER` fires when `insn_done` arrives with an admissible request. `ST_OFFER` holds `take_irq` with a fixed index and vector. The accept transition `ST_OFFER -> ST_IDLE` fires on `take_ack`. On accept the controller sets that level's in-service bit and, if configured, clears the source's pending flag.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A one-cycle strobe on `src_evt[i]` sets pending flag i, visible on `pend_o[i]` the next cycle, whatever the individual or global enables hold.
- R2: A source is eligible only when its pending flag, its enable bit and the effective global enable are all 1. With the global enable 0 (and the window of R10 closed), no source is offered.
- R3: `take_irq` rises only in the cycle after a cycle with `insn_done` high. A pending eligible source without `insn_done` is never offered.
- R4: While `take_irq` is high, `take_idx` holds the chosen source and `vec_addr` equals 0x0003 + 8 * `take_idx`.
- R5: Any eligible high-level source (priority bit 1) wins over all low-level ones. Within a level, the lowest index wins.
- R6: With `inserv_o[0]` (low in service) set, only high-level sources are offered. With `inserv_o[1]` (high in service) set, nothing is offered.
- R7: On accept (`take_ack` while `take_irq`), the source's pending flag is cleared if its entry-clear bit is 1. Otherwise it stays set until a software clear on `pend_clr[i]`.
- R8: An event and a software clear on the same flag in the same cycle leave the flag set.
- R9: `reti` clears `inserv_o[1]` if set, otherwise `inserv_o[0]`. A flag still pending after the return is offered again at the next eligible boundary.
- R10: After `gen_wr` writes 0, `gen_o` reads 0 at once. At the next boundary a pending enabled source is still offered if `next_multi` is 0 and not offered if `next_multi` is 1. Later boundaries offer nothing.
- R11: After synchronous reset, pending flags, enables, in-service bits and the global enable are 0, and `take_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_evt | input | 14 | Per-source event strobes |
| pend_clr | input | 14 | Per-source software clear strobes |
| en_wr | input | 1 | Load individual enables |
| en_wdata | input | 14 | Enable value |
| prio_wr | input | 1 | Load level bits |
| prio_wdata | input | 14 | Level value, 1 = high |
| hwclr_wr | input | 1 | Load entry-clear bits |
| hwclr_wdata | input | 14 | Entry-clear value |
| gen_wr | input | 1 | Load global enable |
| gen_wdata | input | 1 | Global enable value |
| insn_done | input | 1 | Current instruction completes this cycle |
| next_multi | input | 1 | Next instruction is multi-cycle |
| take_ack | input | 1 | CPU accepts the offered call |
| reti | input | 1 | Return from service routine |
| take_irq | output | 1 | Interrupt call offered |
| take_idx | output | 4 | Offered source index |
| vec_addr | output | 16 | Offered service-routine address |
| pend_o | output | 14 | Pending flags |
| gen_o | output | 1 | Global enable readback |
| inserv_o | output | 2 | In-service bits, [1] high, [0] low |

## Verification
The assertions check on every cycle that an offer begins only after a boundary and only when some view of the global enable was set. They also check that no offer stands while a high-level routine is in service, that each event strobe leaves its flag set, that the chosen index is a requesting source, and that a return retires the high level. Only the bench scenarios can show the arbitration order over mixed patterns, the exact vector per index, the per-source entry-clear choice, re-offering after a return, and the one-instruction window with both values of the multi-cycle hint.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } irq_state_e;

    localparam int unsigned LVL_LOW  = 0;
    localparam int unsigned LVL_HIGH = 1;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N_SRC = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);
    logic [N_SRC-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_chk
        // R1 R8
        evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> pend_o[g]);
    end
endmodule

// File: rtl/irq_lowest.sv
module irq_lowest #(
    parameter int N_SRC = 14,
    parameter int IDX_W = 4
) (
    input  logic [N_SRC-1:0] req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_gen_gate.sv
module irq_gen_gate (
    input  logic clk,
    input  logic rst,
    input  logic gen_q,
    input  logic insn_done,
    input  logic next_multi,
    output logic eff_o,
    output logic shadow_o
);
    logic shadow_q;

    always_ff @(posedge clk) begin
        if (rst)            shadow_q <= 1'b0;
        else if (insn_done) shadow_q <= gen_q;
    end

    assign eff_o    = gen_q | (shadow_q & ~next_multi);
    assign shadow_o = shadow_q;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
#(
    parameter int N_SRC     = 14,
    parameter int VEC_W     = 16,
    parameter int VEC_BASE  = 3,
    parameter int VEC_STEP  = 8,
    localparam int IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_evt,
    input  logic [N_SRC-1:0] pend_clr,
    input  logic             en_wr,
    input  logic [N_SRC-1:0] en_wdata,
    input  logic             prio_wr,
    input  logic [N_SRC-1:0] prio_wdata,
    input  logic             hwclr_wr,
    input  logic [N_SRC-1:0] hwclr_wdata,
    input  logic             gen_wr,
    input  logic             gen_wdata,
    input  logic             insn_done,
    input  logic             next_multi,
    input  logic             take_ack,
    input  logic             reti,
    output logic             take_irq,
    output logic [IDX_W-1:0] take_idx,
    output logic [VEC_W-1:0] vec_addr,
    output logic [N_SRC-1:0] pend_o,
    output logic             gen_o,
    output logic [1:0]       inserv_o
);
    irq_state_e       state_q, state_n;
    logic [N_SRC-1:0] en_q, prio_q, hwclr_q, pend, clr_mask, req, req_hi, req_lo;
    logic             gen_q, gen_eff, gen_shadow;
    logic             hi_any, lo_any, hi_ok, lo_ok, launch, accept;
    logic [IDX_W-1:0] hi_idx, lo_idx, sel_idx_q;
    logic             sel_lvl_q;
    logic [1:0]       inserv_q, inserv_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            prio_q  <= '0;
            hwclr_q <= '0;
            gen_q   <= 1'b0;
        end else begin
            if (en_wr)    en_q    <= en_wdata;
            if (prio_wr)  prio_q  <= prio_wdata;
            if (hwclr_wr) hwclr_q <= hwclr_wdata;
            if (gen_wr)   gen_q   <= gen_wdata;
        end
    end

    irq_gen_gate u_gate (
        .clk(clk), .rst(rst), .gen_q(gen_q), .insn_done(insn_done),
        .next_multi(next_multi), .eff_o(gen_eff), .shadow_o(gen_shadow)
    );

    irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
        .clk(clk), .rst(rst), .set_i(src_evt), .clr_i(clr_mask), .pend_o(pend)
    );

    assign req    = pend & en_q & {N_SRC{gen_eff}};
    assign req_hi = req & prio_q;
    assign req_lo = req & ~prio_q;

    irq_lowest #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_hi (
        .req_i(req_hi), .any_o(hi_any), .idx_o(hi_idx)
    );
    irq_lowest #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_lo (
        .req_i(req_lo), .any_o(lo_any), .idx_o(lo_idx)
    );

    assign hi_ok  = hi_any & ~inserv_q[LVL_HIGH];
    assign lo_ok  = lo_any & (inserv_q == 2'b00);
    assign launch = (state_q == ST_IDLE) & insn_done & (hi_ok | lo_ok);
    assign accept = (state_q == ST_OFFER) & take_ack;

    always_comb begin
        clr_mask = pend_clr;
        if (accept && hwclr_q[sel_idx_q]) clr_mask[sel_idx_q] = 1'b1;
    end

    always_comb begin
        inserv_n = inserv_q;
        if (reti) begin
            if (inserv_n[LVL_HIGH]) inserv_n[LVL_HIGH] = 1'b0;
            else                    inserv_n[LVL_LOW]  = 1'b0;
        end
        if (accept) inserv_n[sel_lvl_q] = 1'b1;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_n = ST_OFFER;
            ST_OFFER: if (accept) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            sel_idx_q <= '0;
            sel_lvl_q <= 1'b0;
            inserv_q  <= 2'b00;
        end else begin
            state_q  <= state_n;
            inserv_q <= inserv_n;
            if (launch) begin
                sel_idx_q <= hi_ok ? hi_idx : lo_idx;
                sel_lvl_q <= hi_ok;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_OFFER: take_irq = 1'b1;
            default:  take_irq = 1'b0;
        endcase
        take_idx = sel_idx_q;
        vec_addr = VEC_W'(VEC_BASE) + VEC_W'(sel_idx_q) * VEC_W'(VEC_STEP);
    end

    assign pend_o   = pend;
    assign gen_o    = gen_q;
    assign inserv_o = inserv_q;

    // R3
    offer_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(take_irq) |-> $past(insn_done));
    // R2
    offer_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(take_irq) |-> ($past(gen_q) || $past(gen_shadow)));
    // R6
    no_offer_in_high_chk: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> !inserv_q[LVL_HIGH]);
    // R5
    hi_pick_valid_chk: assert property (@(posedge clk) disable iff (rst)
        hi_any |-> req_hi[hi_idx]);
    // R4
    idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> (int'(take_idx) < N_SRC));
    // R9
    reti_drops_high_chk: assert property (@(posedge clk) disable iff (rst)
        (reti && inserv_q[LVL_HIGH]) |=> !inserv_q[LVL_HIGH]);
endmodule

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
    localparam int N = 14;
    localparam logic [N-1:0] ALL = {N{1'b1}};

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0] src_evt, pend_clr, en_wdata, prio_wdata, hwclr_wdata;
    logic en_wr, prio_wr, hwclr_wr, gen_wr, gen_wdata;
    logic insn_done, next_multi, take_ack, reti;
    logic take_irq;
    logic [3:0] take_idx;
    logic [15:0] vec_addr;
    logic [N-1:0] pend_o;
    logic gen_o;
    logic [1:0] inserv_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    irq_vec_ctrl uut (
        .clk(clk), .rst(rst), .src_evt(src_evt), .pend_clr(pend_clr),
        .en_wr(en_wr), .en_wdata(en_wdata), .prio_wr(prio_wr), .prio_wdata(prio_wdata),
        .hwclr_wr(hwclr_wr), .hwclr_wdata(hwclr_wdata), .gen_wr(gen_wr), .gen_wdata(gen_wdata),
        .insn_done(insn_done), .next_multi(next_multi), .take_ack(take_ack), .reti(reti),
        .take_irq(take_irq), .take_idx(take_idx), .vec_addr(vec_addr),
        .pend_o(pend_o), .gen_o(gen_o), .inserv_o(inserv_o)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_en(input logic [N-1:0] v);
        en_wr = 1; en_wdata = v; tick(); en_wr = 0;
    endtask
    task automatic wr_prio(input logic [N-1:0] v);
        prio_wr = 1; prio_wdata = v; tick(); prio_wr = 0;
    endtask
    task automatic wr_hwclr(input logic [N-1:0] v);
        hwclr_wr = 1; hwclr_wdata = v; tick(); hwclr_wr = 0;
    endtask
    task automatic wr_gen(input logic v);
        gen_wr = 1; gen_wdata = v; tick(); gen_wr = 0;
    endtask
    task automatic evt(input logic [N-1:0] v);
        src_evt = v; tick(); src_evt = '0;
    endtask
    task automatic boundary(input logic multi);
        insn_done = 1; next_multi = multi; tick(); insn_done = 0; next_multi = 0;
    endtask
    task automatic ack();
        take_ack = 1; tick(); take_ack = 0;
    endtask
    task automatic do_reti();
        reti = 1; tick(); reti = 0;
    endtask
    task automatic clear_all();
        pend_clr = ALL; tick(); pend_clr = '0;
    endtask

    function automatic int pick(input logic [N-1:0] p, input logic [N-1:0] pr);
        for (int i = 0; i < N; i++) if (p[i] && pr[i]) return i;
        for (int i = 0; i < N; i++) if (p[i]) return i;
        return -1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; src_evt = '0; pend_clr = '0; en_wr = 0; en_wdata = '0;
        prio_wr = 0; prio_wdata = '0; hwclr_wr = 0; hwclr_wdata = '0;
        gen_wr = 0; gen_wdata = 0; insn_done = 0; next_multi = 0; take_ack = 0; reti = 0;
        repeat (3) tick();
        rst = 0;
        // R11 reset state
        chk("R11 pend", 32'(pend_o), 0);
        chk("R11 gen", 32'(gen_o), 0);
        chk("R11 inserv", 32'(inserv_o), 0);
        chk("R11 take", 32'(take_irq), 0);

        // R1 flags latch with everything disabled
        for (int i = 0; i < N; i++) begin
            evt(N'(1) << i);
            chk("R1 latch", 32'(pend_o), 32'(N'(1) << i));
            boundary(0);
            chk("R2 no offer when disabled", 32'(take_irq), 0);
            pend_clr = N'(1) << i; tick(); pend_clr = '0;
            chk("R7 sw clear", 32'(pend_o), 0);
        end

        // R2 global on but individual enable off
        wr_gen(1);
        evt(N'(1) << 6);
        boundary(0);
        chk("R2 indiv off", 32'(take_irq), 0);
        clear_all();

        // R4 vector sweep over every source, entry clear on
        wr_en(ALL); wr_hwclr(ALL);
        for (int i = 0; i < N; i++) begin
            evt(N'(1) << i);
            repeat (2) tick();
            chk("R3 no boundary no offer", 32'(take_irq), 0);
            boundary(0);
            chk("R3 offer", 32'(take_irq), 1);
            chk("R4 idx", 32'(take_idx), 32'(i));
            chk("R4 vec", 32'(vec_addr), 32'(3 + 8 * i));
            ack();
            chk("R7 hw clear", 32'(pend_o), 0);
            chk("R6 low in service", 32'(inserv_o), 1);
            do_reti();
            chk("R9 reti low", 32'(inserv_o), 0);
        end

        // R5 mixed pattern sweep
        wr_hwclr('0);
        for (int k = 1; k <= 24; k++) begin
            logic [N-1:0] pat, pr;
            int e;
            pat = N'((k * 32'h1357) ^ (k << 5));
            if (pat == '0) pat = N'(k);
            pr  = N'(k * 32'h2B1);
            wr_prio(pr);
            evt(pat);
            boundary(0);
            e = pick(pat, pr);
            chk("R5 offer", 32'(take_irq), 1);
            chk("R5 pick", 32'(take_idx), 32'(e));
            ack();
            chk("R7 flag kept", 32'(pend_o), 32'(pat));
            do_reti();
            clear_all();
        end

        // R6 preemption
        wr_hwclr(ALL); wr_prio(N'(12)); // sources 2,3 high
        evt(N'(1) << 7); boundary(0); chk("R6 low taken", 32'(take_idx), 7); ack();
        evt(N'(1) << 9); boundary(0); chk("R6 low blocked by low", 32'(take_irq), 0);
        evt(N'(1) << 2); boundary(0);
        chk("R6 high preempts", 32'(take_irq), 1);
        chk("R6 high idx", 32'(take_idx), 2);
        ack(); chk("R6 both in service", 32'(inserv_o), 3);
        evt(N'(1) << 3); boundary(0); chk("R6 high blocked", 32'(take_irq), 0);
        do_reti(); chk("R9 high retired", 32'(inserv_o), 1);
        boundary(0); chk("R6 high after reti", 32'(take_idx), 3); ack();
        do_reti();
        boundary(0); chk("R6 low still blocked", 32'(take_irq), 0);
        do_reti(); chk("R9 low retired", 32'(inserv_o), 0);
        boundary(0); chk("R9 pending low offered", 32'(take_idx), 9); ack(); do_reti();
        wr_prio('0);

        // R9 re-offer with flag kept
        wr_hwclr(~(N'(1) << 4));
        evt(N'(1) << 4); boundary(0); ack();
        chk("R7 entry clear off", 32'(pend_o[4]), 1);
        do_reti();
        boundary(0);
        chk("R9 re-offer", 32'(take_irq), 1);
        chk("R9 re-offer idx", 32'(take_idx), 4);
        ack(); do_reti(); clear_all();

        // R8 event and clear together
        src_evt = N'(1) << 11; pend_clr = N'(1) << 11; tick();
        src_evt = '0; pend_clr = '0;
        chk("R8 set wins", 32'(pend_o[11]), 1);
        clear_all();

        // R10 window, single-cycle next
        wr_hwclr(ALL);
        boundary(0);
        wr_gen(0);
        chk("R10 gen reads 0", 32'(gen_o), 0);
        evt(N'(1) << 5);
        boundary(0);
        chk("R10 single-cycle taken", 32'(take_irq), 1);
        chk("R10 idx", 32'(take_idx), 5);
        ack(); do_reti();
        // R10 window, multi-cycle next
        wr_gen(1); boundary(0);
        wr_gen(0);
        evt(N'(1) << 5);
        boundary(1);
        chk("R10 multi-cycle blocked", 32'(take_irq), 0);
        boundary(0);
        chk("R10 window closed", 32'(take_irq), 0);
        chk("R1 flag held", 32'(pend_o[5]), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule